// File: doc/BRIEF.md
# Strap-Selected Test Clock Divider and Rate Decoder

This block sits beside the clock synthesizers of a system clock generator. Three strap inputs are latched once, on the first clock edge after reset is released. Together with one software bit, they pick one of three operating states for seven output clock groups: processor, memory, hub, bus, interrupt controller, serial-bus and reference.

In the released (high-impedance) state every group enable drops and no group clock toggles. In the test state every group is driven from a synchronous integer divider of the single test clock input. Processor, memory and serial-bus groups divide by two. The hub group divides by three with a duty cycle of one and a half input periods high. The bus and interrupt-controller groups divide by six. The reference group follows the test clock itself. All dividers start on the same edge.

In the normal state the block drives no clocks. It reports which processor/memory frequency pair the straps choose, as two small codes for the synthesizers that live elsewhere. The software boost bit can lift the memory rate from 100 to 133 MHz, but only when the straps already select the 133 MHz processor rate with 100 MHz memory. The processor rate never moves when the bit changes.

Top module: `fsel_testdiv`

## Requirements
- R1: While rst_n is low, op_state is 0, grp_oe is all zeros, every group clock output is 0, cpu_rate is 0 and mem_rate is 0.
- R2: strap_in is captured on the first rising clk edge after rst_n rises. Later changes of strap_in have no effect on op_state or grp_oe until the next reset.
- R3: With captured strap_in[2]=0 and strap_in[0]=0, op_state is 0 (released), grp_oe is all zeros and all seven group clocks stay 0, for either value of strap_in[1].
- R4: With captured strap_in[2]=0 and strap_in[0]=1, op_state is 1 (test) and grp_oe is all ones. cpu_clk, mem_clk and usb_clk toggle on every rising clk edge, giving the test clock divided by 2.
- R5: In the test state hub_clk has a period of 3 clk cycles and is high for 1.5 cycles: it rises on a rising edge and falls on the falling edge one and a half cycles later.
- R6: In the test state pci_clk and apic_clk are equal, with a period of 6 clk cycles and 3 cycles high.
- R7: In the test state ref_clk equals clk, starting with the high phase after the first divided edges.
- R8: All dividers rise together on the second rising clk edge after reset release, and again every 6 clk cycles after that.
- R9: With captured strap_in[2]=1, op_state is 2 (normal). The code {strap_in[0],strap_in[1]} maps as follows: 00 gives cpu_rate 0 (66 MHz) and mem_rate 0 (100 MHz); 10 gives cpu_rate 1 (100 MHz) and mem_rate 0; 01 gives cpu_rate 2 (133 MHz) and mem_rate 1 (133 MHz); 11 gives cpu_rate 2 and mem_rate 0.
- R10: mem_boost is registered on each rising clk edge. With code 11 in the normal state, a registered mem_boost of 1 makes mem_rate 1; a value set between edges shows after the next rising edge.
- R11: mem_boost never changes cpu_rate, does not change mem_rate for codes 00, 10 or 01, and has no effect on any group clock in the test state.
- R12: In the normal state grp_oe is all ones and every group clock output stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock, also clocks the control registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_in | input | 3 | Strap selects; bit 2 picks normal, bit 0 picks test vs released, bits {0,1} form the rate code |
| mem_boost | input | 1 | Software bit raising memory rate when code is 11 |
| cpu_clk | output | 1 | Processor group clock (test state) |
| mem_clk | output | 1 | Memory group clock (test state) |
| hub_clk | output | 1 | Hub group clock (test state) |
| pci_clk | output | 1 | Bus group clock (test state) |
| apic_clk | output | 1 | Interrupt-controller group clock (test state) |
| usb_clk | output | 1 | Serial-bus group clock (test state) |
| ref_clk | output | 1 | Reference group clock (test state) |
| grp_oe | output | 7 | Per-group drive enable; bit 0 cpu, 1 mem, 2 hub, 3 pci, 4 apic, 5 usb, 6 ref |
| op_state | output | 2 | 0 released, 1 test, 2 normal |
| cpu_rate | output | 2 | 0 = 66 MHz, 1 = 100 MHz, 2 = 133 MHz; 0 outside normal |
| mem_rate | output | 1 | 0 = 100 MHz, 1 = 133 MHz; 0 outside normal |

## Verification
Two functions can meet on a single edge. The boost register loads on the same edge that latches the straps, and in the test state a boost change lands on edges where the dividers switch. The bench holds mem_boost high through reset, then checks that the boosted memory rate appears in the very first normal cycle for code 11 and in no other code. In the test state it flips mem_boost between every pair of edges while it compares each group clock, in both clock phases, with the expected divided waveform.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

   typedef enum logic [1:0] {
      ST_HIZ  = 2'd0,
      ST_TEST = 2'd1,
      ST_NORM = 2'd2
   } op_e;

   localparam logic [1:0] CPU_R66  = 2'd0;
   localparam logic [1:0] CPU_R100 = 2'd1;
   localparam logic [1:0] CPU_R133 = 2'd2;

   localparam int unsigned N_GRP   = 7;
   localparam int unsigned G_CPU   = 0;
   localparam int unsigned G_MEM   = 1;
   localparam int unsigned G_HUB   = 2;
   localparam int unsigned G_PCI   = 3;
   localparam int unsigned G_APIC  = 4;
   localparam int unsigned G_USB   = 5;
   localparam int unsigned G_REF   = 6;

   function automatic op_e op_of(input logic [2:0] s);
      if (s[2])      return ST_NORM;
      else if (s[0]) return ST_TEST;
      else           return ST_HIZ;
   endfunction

   function automatic logic [1:0] cpu_of(input logic [1:0] code);
      case (code)
         2'b00:   return CPU_R66;
         2'b10:   return CPU_R100;
         default: return CPU_R133;
      endcase
   endfunction

   function automatic logic mem_of(input logic [1:0] code, input logic boost);
      case (code)
         2'b01:   return 1'b1;
         2'b11:   return boost;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch #(
   parameter int unsigned SW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [SW-1:0] strap_in,
   output logic [SW-1:0] strap_q,
   output logic          cap_done
);

   if (SW < 3) begin : g_bad_width
      $error("fsel_strap_latch: SW must be at least 3");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strap_q  <= '0;
         cap_done <= 1'b0;
      end else if (!cap_done) begin
         strap_q  <= strap_in;
         cap_done <= 1'b1;
      end
   end

endmodule

// File: rtl/fsel_rate_map.sv
module fsel_rate_map
   import fsel_pkg::*;
#(
   parameter logic BOOST_RST = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] strap_q,
   input  logic       cap_done,
   input  logic       boost_in,
   output op_e        op,
   output logic [1:0] cpu_rate,
   output logic       mem_rate
);

   logic       boost_q;
   logic [1:0] code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) boost_q <= BOOST_RST;
      else        boost_q <= boost_in;
   end

   assign code = {strap_q[0], strap_q[1]};

   always_comb begin
      op       = ST_HIZ;
      cpu_rate = CPU_R66;
      mem_rate = 1'b0;
      if (cap_done) begin
         op = op_of(strap_q);
         if (op == ST_NORM) begin
            cpu_rate = cpu_of(code);
            mem_rate = mem_of(code, boost_q);
         end
      end
   end

endmodule

// File: rtl/fsel_div.sv
module fsel_div #(
   parameter int unsigned DIV           = 2,
   parameter bit          HALF_DUTY_ODD = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic clk_out
);

   if (DIV < 1) begin : g_bad_div
      $error("fsel_div: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      // Enable changes only while clk is low, so the gated clock has no runt pulse.
      logic en_n;
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) en_n <= 1'b0;
         else        en_n <= run;
      end
      assign clk_out = clk & en_n;
   end else begin : g_count
      localparam int unsigned CW   = $clog2(DIV);
      localparam int unsigned LAST = DIV - 1;
      localparam int unsigned HIGH = DIV / 2;

      logic [CW-1:0] cnt;
      logic [CW-1:0] nxt;
      logic          out_q;

      assign nxt = (cnt == CW'(LAST)) ? '0 : cnt + 1'b1;

      // Idle count is LAST so the first running edge lands on phase 0 (rising).
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt   <= CW'(LAST);
            out_q <= 1'b0;
         end else if (run) begin
            cnt   <= nxt;
            out_q <= (nxt < CW'(HIGH));
         end else begin
            cnt   <= CW'(LAST);
            out_q <= 1'b0;
         end
      end

      if ((DIV % 2 == 1) && HALF_DUTY_ODD) begin : g_stretch
         logic ext_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) ext_q <= 1'b0;
            else        ext_q <= out_q;
         end
         assign clk_out = out_q | ext_q;
      end else begin : g_plain
         assign clk_out = out_q;
      end
   end

endmodule

// File: rtl/fsel_testdiv.sv
module fsel_testdiv
   import fsel_pkg::*;
#(
   parameter int unsigned CPU_DIV       = 2,
   parameter int unsigned MEM_DIV       = 2,
   parameter int unsigned HUB_DIV       = 3,
   parameter int unsigned PCI_DIV       = 6,
   parameter int unsigned APIC_DIV      = 6,
   parameter int unsigned USB_DIV       = 2,
   parameter int unsigned REF_DIV       = 1,
   parameter bit          HALF_DUTY_ODD = 1'b1,
   parameter logic        BOOST_RST     = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] strap_in,
   input  logic       mem_boost,
   output logic       cpu_clk,
   output logic       mem_clk,
   output logic       hub_clk,
   output logic       pci_clk,
   output logic       apic_clk,
   output logic       usb_clk,
   output logic       ref_clk,
   output logic [6:0] grp_oe,
   output logic [1:0] op_state,
   output logic [1:0] cpu_rate,
   output logic       mem_rate
);

   localparam int unsigned DIVS [N_GRP] =
      '{CPU_DIV, MEM_DIV, HUB_DIV, PCI_DIV, APIC_DIV, USB_DIV, REF_DIV};

   if (N_GRP != 7) begin : g_bad_groups
      $error("fsel_testdiv: port list assumes seven groups");
   end

   logic [2:0]       strap_q;
   logic             cap_done;
   op_e              op;
   logic             run;
   logic [N_GRP-1:0] grp_clk;

   fsel_strap_latch #(.SW(3)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_in (strap_in),
      .strap_q  (strap_q),
      .cap_done (cap_done)
   );

   fsel_rate_map #(.BOOST_RST(BOOST_RST)) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_q  (strap_q),
      .cap_done (cap_done),
      .boost_in (mem_boost),
      .op       (op),
      .cpu_rate (cpu_rate),
      .mem_rate (mem_rate)
   );

   assign run = (op == ST_TEST);

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      fsel_div #(
         .DIV           (DIVS[g]),
         .HALF_DUTY_ODD (HALF_DUTY_ODD)
      ) u_div (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (run),
         .clk_out (grp_clk[g])
      );
   end

   assign cpu_clk  = grp_clk[G_CPU];
   assign mem_clk  = grp_clk[G_MEM];
   assign hub_clk  = grp_clk[G_HUB];
   assign pci_clk  = grp_clk[G_PCI];
   assign apic_clk = grp_clk[G_APIC];
   assign usb_clk  = grp_clk[G_USB];
   assign ref_clk  = grp_clk[G_REF];

   assign grp_oe   = (op == ST_HIZ) ? '0 : '1;
   assign op_state = op;

endmodule

// File: rtl/fsel_testdiv_chk.sv
module fsel_testdiv_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cap_done,
   input logic [1:0] op_state,
   input logic [6:0] grp_oe,
   input logic [1:0] cpu_rate,
   input logic       mem_rate,
   input logic       cpu_clk,
   input logic       mem_clk,
   input logic       hub_clk,
   input logic       pci_clk,
   input logic       apic_clk,
   input logic       usb_clk,
   input logic       ref_clk
);

   logic [6:0] clk_vec;
   assign clk_vec = {ref_clk, usb_clk, apic_clk, pci_clk, hub_clk, mem_clk, cpu_clk};

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (grp_oe == 7'd0 && op_state == 2'd0)); // R1

   AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cap_done |=> $stable(op_state)); // R2

   AST_HIZ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      op_state == 2'd0 |-> (grp_oe == 7'd0 && clk_vec == 7'd0)); // R3

   AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_state == 2'd1 && $past(op_state) == 2'd1 && $past(op_state, 2) == 2'd1)
      |-> (cpu_clk != $past(cpu_clk))); // R4

   AST_SIXTH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      pci_clk == apic_clk); // R6

   AST_NORM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      op_state == 2'd2 |-> (grp_oe == 7'h7f && clk_vec == 7'd0)); // R12

   AST_BOOST_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rate |-> cpu_rate == 2'd2); // R10

   AST_CPU_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_state == 2'd2 && $past(op_state) == 2'd2) |-> $stable(cpu_rate)); // R11

endmodule

bind fsel_testdiv fsel_testdiv_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cap_done (cap_done),
   .op_state (op_state),
   .grp_oe   (grp_oe),
   .cpu_rate (cpu_rate),
   .mem_rate (mem_rate),
   .cpu_clk  (cpu_clk),
   .mem_clk  (mem_clk),
   .hub_clk  (hub_clk),
   .pci_clk  (pci_clk),
   .apic_clk (apic_clk),
   .usb_clk  (usb_clk),
   .ref_clk  (ref_clk)
);

// File: tb/fsel_testdiv_test.sv
module fsel_testdiv_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] strap_in = 3'b000;
   logic       mem_boost = 1'b0;
   logic       cpu_clk, mem_clk, hub_clk, pci_clk, apic_clk, usb_clk, ref_clk;
   logic [6:0] grp_oe;
   logic [1:0] op_state;
   logic [1:0] cpu_rate;
   logic       mem_rate;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   fsel_testdiv uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_in (strap_in),
      .mem_boost(mem_boost),
      .cpu_clk  (cpu_clk),
      .mem_clk  (mem_clk),
      .hub_clk  (hub_clk),
      .pci_clk  (pci_clk),
      .apic_clk (apic_clk),
      .usb_clk  (usb_clk),
      .ref_clk  (ref_clk),
      .grp_oe   (grp_oe),
      .op_state (op_state),
      .cpu_rate (cpu_rate),
      .mem_rate (mem_rate)
   );

   function automatic int clkv();
      return {ref_clk, usb_clk, apic_clk, pci_clk, hub_clk, mem_clk, cpu_clk};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic apply_reset(input logic [2:0] s, input logic pre_boost);
      @(negedge clk);
      rst_n     = 1'b0;
      strap_in  = s;
      mem_boost = pre_boost;
      @(negedge clk);
      #2;
      chk("R1 op_state in reset", op_state, 0);
      chk("R1 grp_oe in reset", grp_oe, 0);
      chk("R1 clocks in reset", clkv(), 0);
      chk("R1 rates in reset", {cpu_rate, mem_rate}, 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_released(input logic [2:0] s);
      apply_reset(s, 1'b0);
      repeat (4) @(posedge clk);
      #2;
      chk("R3 op_state released", op_state, 0);
      chk("R3 grp_oe released", grp_oe, 0);
      chk("R3 clocks released high phase", clkv(), 0);
      #4;
      chk("R3 clocks released low phase", clkv(), 0);
   endtask

   task automatic t_testmode(input logic boost_toggle);
      apply_reset(3'b001, 1'b0);
      @(posedge clk);
      #2;
      chk("R4 op_state test", op_state, 1);
      chk("R4 grp_oe test", grp_oe, 7'h7f);
      chk("R8 no divider edge before start", clkv() & 7'h3f, 0);
      for (int i = 0; i < 18; i++) begin
         @(posedge clk);
         #2;
         chk("R4 half-rate groups high phase", {usb_clk, mem_clk, cpu_clk},
             (i % 2 == 0) ? 7 : 0);
         chk("R5 hub high phase", hub_clk, (i % 3 != 2) ? 1 : 0);
         chk("R6 sixth-rate groups high phase", {apic_clk, pci_clk},
             (i % 6 < 3) ? 3 : 0);
         chk("R7 ref high phase", ref_clk, 1);
         if (i % 6 == 0)
            chk("R8 joint rising edge", clkv(), 7'h7f);
         if (i == 7) strap_in = 3'b100;
         #4;
         chk("R4 half-rate groups low phase", {usb_clk, mem_clk, cpu_clk},
             (i % 2 == 0) ? 7 : 0);
         chk("R5 hub low phase", hub_clk, (i % 3 == 0) ? 1 : 0);
         chk("R6 sixth-rate groups low phase", {apic_clk, pci_clk},
             (i % 6 < 3) ? 3 : 0);
         chk("R7 ref low phase", ref_clk, 0);
         if (boost_toggle) mem_boost = ~mem_boost;
      end
      chk("R2 strap change ignored (state)", op_state, 1);
      chk("R2 strap change ignored (enables)", grp_oe, 7'h7f);
      chk("R11 no rate report in test", {cpu_rate, mem_rate}, 0);
   endtask

   task automatic t_normal(input logic [2:0] s, input logic pre_boost,
                           input int exp_cpu, input int exp_mem0, input int exp_mem1);
      apply_reset(s, pre_boost);
      @(posedge clk);
      #2;
      chk("R9 op_state normal", op_state, 2);
      chk("R12 grp_oe normal", grp_oe, 7'h7f);
      chk("R9 cpu_rate first cycle", cpu_rate, exp_cpu);
      chk("R10 mem_rate first cycle", mem_rate, pre_boost ? exp_mem1 : exp_mem0);
      #4;
      chk("R12 clocks low in normal", clkv(), 0);
      mem_boost = ~pre_boost;
      #2;
      chk("R10 boost not seen before edge", mem_rate, pre_boost ? exp_mem1 : exp_mem0);
      @(posedge clk);
      #2;
      chk("R10 mem_rate after boost change", mem_rate, pre_boost ? exp_mem0 : exp_mem1);
      chk("R11 cpu_rate unmoved by boost", cpu_rate, exp_cpu);
      @(negedge clk);
      mem_boost = pre_boost;
      strap_in  = ~s;
      @(posedge clk);
      #2;
      chk("R10 mem_rate restored", mem_rate, pre_boost ? exp_mem1 : exp_mem0);
      chk("R2 strap change ignored (cpu_rate)", cpu_rate, exp_cpu);
      chk("R12 clocks still low", clkv(), 0);
   endtask

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_released(3'b000);
      t_released(3'b010);
      t_testmode(1'b0);
      t_testmode(1'b1);
      // code {strap[0],strap[1]}: 00, 10, 01, 11
      t_normal(3'b100, 1'b0, 0, 0, 0);
      t_normal(3'b101, 1'b0, 1, 0, 0);
      t_normal(3'b110, 1'b0, 2, 1, 1);
      t_normal(3'b111, 1'b0, 2, 0, 1);
      t_normal(3'b111, 1'b1, 2, 0, 1);
      t_normal(3'b101, 1'b1, 1, 0, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule